// File: doc/BRIEF.md
# Parity-Checked Reversible 2-to-4 Decoder Array

This block holds several copies of a 2-to-4 decoder with enable. Each decoder is a chain of three controlled-swap cells. When the control line of a controlled-swap cell is 1, the cell exchanges its two data lines. The control line itself always passes through unchanged. Each cell is wrapped in a self-testing shell with two stages. The first stage folds the cell's outputs into a parity bit, starting from a seed. A second stage passes the lines through unchanged and folds them into a second parity bit from its own seed. A single wrong line between the stages, or a wrong parity line, makes the two parity bits disagree.

Each decoder copy has a test cell. It ORs the disagreement of its three cells into a per-copy error flag, and an invert input can XOR that flag. The flags of the copies feed a two-level tree of OR-combiners: first into group flags, then into one root flag. Every combiner has its own invert input. Each line between the stages and each parity line can be flipped through a fault mask, so that online error detection can be exercised. All outputs are registered once.

Top module: `rdec_array`

## Requirements
- R1: While rst_ni is low, dec_o, tflag_o, grp_o and mmt_o are all 0.
- R2: Each output shows the result of the inputs sampled at the previous rising clock edge, with a latency of exactly one cycle.
- R3: For copy m, with en_i[m]=1 and no fault, dec_o[4m +: 4] is one-hot. The set bit is at index 2*a_i[m] + b_i[m].
- R4: For copy m, with en_i[m]=0 and no fault, dec_o[4m +: 4] is 0 whatever a_i[m] and b_i[m] are.
- R5: With fault_i all zero and all invert inputs 0, tflag_o, grp_o and mmt_o are 0 for every input pattern.
- R6: fault_i holds 15 bits per copy. Copy m uses bits [15m +: 15], and cell k of that copy uses bits [5k +: 5] within them. In a cell's 5 bits, bits 0..2 flip the lines between the stages and bits 3 and 4 flip the two parity outputs. Any single set bit drives tflag_o[m] to 1 and leaves the other copies' flags at 0, for every input pattern.
- R7: With par_opp_i=1, the second parity seed is the opposite of the first, and a match counts as an error. R5 and R6 then hold unchanged.
- R8: tflag_o[m] equals the error condition of copy m XOR tc_inv_i[m].
- R9: grp_o[g] equals the OR of tflag_o over copies g*GRP_SIZE to g*GRP_SIZE+GRP_SIZE-1, XOR grp_inv_i[g].
- R10: mmt_o equals the OR of grp_o, XOR root_inv_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | NUM_MOD | Address high bit per copy |
| b_i | input | NUM_MOD | Address low bit per copy |
| en_i | input | NUM_MOD | Enable per copy |
| par_opp_i | input | 1 | 1: parity seeds opposite; 0: seeds equal |
| fault_i | input | 15*NUM_MOD | Fault mask XORed onto internal nets |
| tc_inv_i | input | NUM_MOD | Invert input of each test cell |
| grp_inv_i | input | NUM_MOD/GRP_SIZE | Invert input of each group combiner |
| root_inv_i | input | 1 | Invert input of the root combiner |
| dec_o | output | 4*NUM_MOD | Decoder outputs, 4 bits per copy |
| tflag_o | output | NUM_MOD | Test-cell error flag per copy |
| grp_o | output | NUM_MOD/GRP_SIZE | Group error flags |
| mmt_o | output | 1 | Root error flag |

## Verification
A corrupted line between the two stages of any cell reaches the ports on the next rising edge. The owning copy's flag rises, and so do its group flag and the root flag. The decoder word may also go wrong, or may stay correct when the corrupted line is a control line that only feeds garbage.

A stuck or wrong parity seed shows up the same way in the cycle after it is applied, even though the decoder outputs stay clean. The bench therefore walks every single mask bit across every address and enable pattern, in both seed polarities.

// File: rtl/rdec_pkg.sv
package rdec_pkg;
  localparam int unsigned CELL_LINES = 3;
  localparam int unsigned CELL_FBITS = CELL_LINES + 2;
  localparam int unsigned DEC_CELLS  = 3;
  localparam int unsigned DEC_FBITS  = DEC_CELLS * CELL_FBITS;
  localparam int unsigned DEC_OUTS   = 4;

  typedef logic [CELL_LINES-1:0] lines_t;  // bit0 control, bit1/bit2 data
endpackage

// File: rtl/rdec_cswap.sv
module rdec_cswap
  import rdec_pkg::*;
(
  input  lines_t in_i,
  output lines_t out_o
);
  always_comb begin
    out_o[0] = in_i[0];
    out_o[1] = in_i[0] ? in_i[2] : in_i[1];
    out_o[2] = in_i[0] ? in_i[1] : in_i[2];
  end
endmodule

// File: rtl/rdec_tcell.sv
module rdec_tcell
  import rdec_pkg::*;
(
  input  lines_t                in_i,
  input  logic                  pia_i,
  input  logic                  pib_i,
  input  logic [CELL_FBITS-1:0] flt_i,
  output lines_t                out_o,
  output logic                  poa_o,
  output logic                  pob_o
);
  lines_t gate_out;
  lines_t mid;

  rdec_cswap u_gate (.in_i(in_i), .out_o(gate_out));

  // first stage: parity of gate outputs
  assign poa_o = pia_i ^ (^gate_out) ^ flt_i[CELL_LINES];
  // interconnect between stages, fault-injectable
  assign mid   = gate_out ^ flt_i[CELL_LINES-1:0];
  // identity stage with its own parity
  assign out_o = mid;
  assign pob_o = pib_i ^ (^mid) ^ flt_i[CELL_LINES+1];
endmodule

// File: rtl/rdec_orcell.sv
module rdec_orcell #(
  parameter int unsigned WIDTH = 2
) (
  input  logic [WIDTH-1:0] in_i,
  input  logic             inv_i,
  output logic             flag_o
);
  assign flag_o = (|in_i) ^ inv_i;
endmodule

// File: rtl/rdec_module.sv
module rdec_module
  import rdec_pkg::*;
(
  input  logic                 a_i,
  input  logic                 b_i,
  input  logic                 en_i,
  input  logic                 par_opp_i,
  input  logic [DEC_FBITS-1:0] flt_i,
  input  logic                 tc_inv_i,
  output logic [DEC_OUTS-1:0]  dec_o,
  output logic                 tflag_o
);
  lines_t                cin  [DEC_CELLS];
  lines_t                cout [DEC_CELLS];
  logic [DEC_CELLS-1:0]  poa, pob, mism;

  // cell 0 splits enable on a; cells 1 and 2 split on b (control chained)
  assign cin[0] = {1'b0, en_i, a_i};
  assign cin[1] = {1'b0, cout[0][1], b_i};
  assign cin[2] = {1'b0, cout[0][2], cout[1][0]};

  for (genvar k = 0; k < DEC_CELLS; k++) begin : g_cell
    rdec_tcell u_tc (
      .in_i  (cin[k]),
      .pia_i (1'b0),
      .pib_i (par_opp_i),
      .flt_i (flt_i[k*CELL_FBITS +: CELL_FBITS]),
      .out_o (cout[k]),
      .poa_o (poa[k]),
      .pob_o (pob[k])
    );
    assign mism[k] = poa[k] ^ pob[k] ^ par_opp_i;
  end

  assign dec_o = {cout[2][2], cout[2][1], cout[1][2], cout[1][1]};

  rdec_orcell #(.WIDTH(DEC_CELLS)) u_test (
    .in_i  (mism),
    .inv_i (tc_inv_i),
    .flag_o(tflag_o)
  );
endmodule

// File: rtl/rdec_array.sv
module rdec_array
  import rdec_pkg::*;
#(
  parameter int unsigned NUM_MOD  = 4,
  parameter int unsigned GRP_SIZE = 2,
  localparam int unsigned NUM_GRP = NUM_MOD / GRP_SIZE
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_MOD-1:0]            a_i,
  input  logic [NUM_MOD-1:0]            b_i,
  input  logic [NUM_MOD-1:0]            en_i,
  input  logic                          par_opp_i,
  input  logic [NUM_MOD*DEC_FBITS-1:0]  fault_i,
  input  logic [NUM_MOD-1:0]            tc_inv_i,
  input  logic [NUM_GRP-1:0]            grp_inv_i,
  input  logic                          root_inv_i,
  output logic [NUM_MOD*DEC_OUTS-1:0]   dec_o,
  output logic [NUM_MOD-1:0]            tflag_o,
  output logic [NUM_GRP-1:0]            grp_o,
  output logic                          mmt_o
);
  logic [NUM_MOD*DEC_OUTS-1:0] dec_d;
  logic [NUM_MOD-1:0]          tflag_d;
  logic [NUM_GRP-1:0]          grp_d;
  logic                        mmt_d;

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    rdec_module u_mod (
      .a_i      (a_i[m]),
      .b_i      (b_i[m]),
      .en_i     (en_i[m]),
      .par_opp_i(par_opp_i),
      .flt_i    (fault_i[m*DEC_FBITS +: DEC_FBITS]),
      .tc_inv_i (tc_inv_i[m]),
      .dec_o    (dec_d[m*DEC_OUTS +: DEC_OUTS]),
      .tflag_o  (tflag_d[m])
    );
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    rdec_orcell #(.WIDTH(GRP_SIZE)) u_comb (
      .in_i  (tflag_d[g*GRP_SIZE +: GRP_SIZE]),
      .inv_i (grp_inv_i[g]),
      .flag_o(grp_d[g])
    );
  end

  rdec_orcell #(.WIDTH(NUM_GRP)) u_root (
    .in_i  (grp_d),
    .inv_i (root_inv_i),
    .flag_o(mmt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_o   <= '0;
      tflag_o <= '0;
      grp_o   <= '0;
      mmt_o   <= 1'b0;
    end else begin
      dec_o   <= dec_d;
      tflag_o <= tflag_d;
      grp_o   <= grp_d;
      mmt_o   <= mmt_d;
    end
  end
endmodule

// File: rtl/rdec_array_chk.sv
module rdec_array_chk
  import rdec_pkg::*;
#(
  parameter int unsigned NUM_MOD  = 4,
  parameter int unsigned GRP_SIZE = 2,
  localparam int unsigned NUM_GRP = NUM_MOD / GRP_SIZE
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_MOD-1:0]            a_i,
  input logic [NUM_MOD-1:0]            b_i,
  input logic [NUM_MOD-1:0]            en_i,
  input logic                          par_opp_i,
  input logic [NUM_MOD*DEC_FBITS-1:0]  fault_i,
  input logic [NUM_MOD-1:0]            tc_inv_i,
  input logic [NUM_GRP-1:0]            grp_inv_i,
  input logic                          root_inv_i,
  input logic [NUM_MOD*DEC_OUTS-1:0]   dec_o,
  input logic [NUM_MOD-1:0]            tflag_o,
  input logic [NUM_GRP-1:0]            grp_o,
  input logic                          mmt_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (dec_o == '0 && tflag_o == '0 && grp_o == '0 && !mmt_o); // R1
    end
  end

  AST_CLEAN_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(fault_i) == '0 && $past(tc_inv_i) == '0 |-> tflag_o == '0); // R5

  AST_SINGLE_FAULT_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $onehot($past(fault_i)) && $past(tc_inv_i) == '0 |-> $countones(tflag_o) == 1); // R6

  AST_ROOT_TRACKS_GROUPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && !$past(root_inv_i) |-> mmt_o == (|grp_o)); // R10

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_m
    AST_DEC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && $past(fault_i) == '0 && $past(en_i[m])
      |-> $countones(dec_o[m*DEC_OUTS +: DEC_OUTS]) == 1); // R3

    AST_DEC_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && $past(fault_i) == '0 && !$past(en_i[m])
      |-> dec_o[m*DEC_OUTS +: DEC_OUTS] == '0); // R4
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_g
    AST_GROUP_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && !$past(grp_inv_i[g]) |-> grp_o[g] == (|tflag_o[g*GRP_SIZE +: GRP_SIZE])); // R9
  end
endmodule

bind rdec_array rdec_array_chk #(.NUM_MOD(NUM_MOD), .GRP_SIZE(GRP_SIZE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .en_i(en_i),
  .par_opp_i(par_opp_i), .fault_i(fault_i), .tc_inv_i(tc_inv_i),
  .grp_inv_i(grp_inv_i), .root_inv_i(root_inv_i), .dec_o(dec_o),
  .tflag_o(tflag_o), .grp_o(grp_o), .mmt_o(mmt_o)
);

// File: tb/rdec_array_test.sv
module rdec_array_test;
  localparam int NUM_MOD  = 4;
  localparam int GRP_SIZE = 2;
  localparam int NUM_GRP  = NUM_MOD / GRP_SIZE;
  localparam int FB       = 15;
  localparam int CLK_PER  = 10;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic [NUM_MOD-1:0]      a_i = '0, b_i = '0, en_i = '0, tc_inv_i = '0;
  logic                    par_opp_i = 1'b0, root_inv_i = 1'b0;
  logic [NUM_MOD*FB-1:0]   fault_i = '0;
  logic [NUM_GRP-1:0]      grp_inv_i = '0;
  logic [NUM_MOD*4-1:0]    dec_o;
  logic [NUM_MOD-1:0]      tflag_o;
  logic [NUM_GRP-1:0]      grp_o;
  logic                    mmt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PER/2) clk_i = ~clk_i;

  rdec_array #(.NUM_MOD(NUM_MOD), .GRP_SIZE(GRP_SIZE)) uut (
    .clk_i, .rst_ni, .a_i, .b_i, .en_i, .par_opp_i, .fault_i, .tc_inv_i,
    .grp_inv_i, .root_inv_i, .dec_o, .tflag_o, .grp_o, .mmt_o
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_dec(input logic a, input logic b, input logic e);
    return e ? (4'b0001 << {a, b}) : 4'b0000;
  endfunction

  // inputs settle, one edge registers them, sample 1 time unit later
  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic set_all(input int combo);
    for (int m = 0; m < NUM_MOD; m++) begin
      a_i[m]  = combo[2];
      b_i[m]  = combo[1];
      en_i[m] = combo[0];
    end
  endtask

  task automatic t_reset();
    a_i = '1; b_i = '1; en_i = '1; tc_inv_i = '1; root_inv_i = 1'b1;
    #(CLK_PER * 2);
    chk("R1 dec", dec_o, '0);
    chk("R1 tflag", tflag_o, '0);
    chk("R1 grp", grp_o, '0);
    chk("R1 mmt", mmt_o, 0);
    tc_inv_i = '0; root_inv_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    step();
  endtask

  task automatic t_decode();
    for (int i = 0; i < 8; i++) begin
      logic [NUM_MOD*4-1:0] exp;
      for (int m = 0; m < NUM_MOD; m++) begin
        int c = (i + m) % 8;
        a_i[m] = c[2]; b_i[m] = c[1]; en_i[m] = c[0];
        exp[m*4 +: 4] = exp_dec(c[2], c[1], c[0]);
      end
      step();
      chk("R3 R4 decode", dec_o, exp);
    end
  endtask

  task automatic t_latency();
    set_all(3'b001);
    step();
    set_all(3'b111);
    #2;
    chk("R2 hold before edge", dec_o, {NUM_MOD{4'b0001}});
    step();
    chk("R2 update after edge", dec_o, {NUM_MOD{4'b1000}});
  endtask

  task automatic t_enable_low();
    for (int c = 0; c < 8; c += 2) begin
      set_all(c);
      step();
      chk("R4 disabled", dec_o, '0);
    end
  endtask

  task automatic t_clean(input logic opp);
    par_opp_i = opp;
    for (int c = 0; c < 8; c++) begin
      set_all(c);
      fault_i = '0;
      step();
      chk(opp ? "R7 clean tflag" : "R5 clean tflag", tflag_o, '0);
      chk(opp ? "R7 clean grp" : "R5 clean grp", grp_o, '0);
      chk(opp ? "R7 clean mmt" : "R5 clean mmt", mmt_o, 0);
    end
  endtask

  task automatic t_single_fault(input logic opp);
    par_opp_i = opp;
    for (int m = 0; m < NUM_MOD; m++)
      for (int bt = 0; bt < FB; bt++)
        for (int c = 0; c < 8; c++) begin
          set_all(c);
          fault_i = '0;
          fault_i[m*FB + bt] = 1'b1;
          step();
          chk(opp ? "R7 fault tflag" : "R6 fault tflag", tflag_o, 64'(1) << m);
          chk(opp ? "R7 fault grp" : "R9 fault grp", grp_o, 64'(1) << (m / GRP_SIZE));
          chk(opp ? "R7 fault mmt" : "R10 fault mmt", mmt_o, 1);
        end
    fault_i = '0;
    par_opp_i = 1'b0;
  endtask

  task automatic t_tree();
    set_all(3'b011);
    tc_inv_i = 4'b0100;
    step();
    chk("R8 inverted test cell", tflag_o, 4'b0100);
    chk("R9 group follows", grp_o, 2'b10);
    chk("R10 root follows", mmt_o, 1);
    grp_inv_i = 2'b01;
    step();
    chk("R9 group invert", grp_o, 2'b11);
    root_inv_i = 1'b1;
    step();
    chk("R10 root invert with error", mmt_o, 0);
    tc_inv_i = '0; grp_inv_i = '0;
    step();
    chk("R10 root invert clean", mmt_o, 1);
    root_inv_i = 1'b0;
    fault_i[3*FB + 2] = 1'b1;
    tc_inv_i = 4'b1000;
    step();
    chk("R8 invert cancels fault", tflag_o, '0);
    fault_i = '0; tc_inv_i = '0;
  endtask

  initial begin
    t_reset();
    t_decode();
    t_latency();
    t_enable_low();
    t_clean(1'b0);
    t_clean(1'b1);
    t_single_fault(1'b0);
    t_single_fault(1'b1);
    t_tree();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule